// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one PCI device function. A host-side agent issues accesses of 1, 2 or 4 bytes at a byte offset. Each access gets a registered response one cycle later, which carries read data and an error flag. The power-on contents come from parameters: identifiers, class code, subsystem identifiers, interrupt pin and line, the initial attribute bits of six base address registers (BARs) and the size of the window each BAR claims.

Writes are filtered per register and per access width. Only the command, status, cache line size, latency timer, interrupt line, BAR and expansion ROM fields can change. The BARs support the usual sizing handshake. Writing all ones makes a BAR read back the inverted size mask, and its read-only attribute bits are always kept. An illegal access width, a misaligned or out-of-range offset, or a narrow write to a protected field sets the error flag. A word-wide write to a protected field is dropped without any error.

Top module: `cfg_header_regs`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. A write commits at that same edge, so a read issued in the next cycle sees it. A write response always carries `rsp_rdata` = 0.
- R2: After reset the header reads as follows. Vendor ID is at 0x00 and device ID at 0x02 (16 bits each). Command is at 0x04 and status at 0x06. Revision is at 0x08, and the three class bytes (programming interface, subclass, base class) are at 0x09–0x0B. Cache line size is at 0x0C, latency timer at 0x0D and header type at 0x0E. BAR n is at 0x10+4n. Subsystem vendor is at 0x2C and subsystem ID at 0x2E. Expansion ROM is at 0x30, interrupt line at 0x3C and interrupt pin at 0x3D. All other bytes are 0.
- R3: Read data is little-endian: byte k of an access comes from offset+k. Reads of 1 or 2 bytes are zero-extended to 32 bits.
- R4: A size code other than 1, 2 or 4 sets `rsp_err`, returns zero and changes nothing.
- R5: The access is rejected when it is misaligned (2-byte at an odd offset, 4-byte at an offset not a multiple of 4) or when its offset is 64 or more. A rejected access sets `rsp_err`, returns zero and changes nothing.
- R6: A 1-byte write updates the byte only at 0x0C, 0x0D or 0x3C. At any other offset it sets `rsp_err` and changes nothing.
- R7: A 2-byte write updates both bytes only at 0x04, 0x06 or 0x0C. At any other offset it sets `rsp_err` and changes nothing.
- R8: A 4-byte write at 0x04 updates only the command bytes 0x04–0x05 and leaves status unchanged. A 4-byte write to a BAR or to 0x30 takes effect. Any other 4-byte write is dropped with `rsp_err` low.
- R9: A BAR whose reset value has bit 0 set is an I/O BAR, and its bits 1:0 are read-only. Any other BAR is a memory BAR, and its bits 3:0 are read-only. A write other than 0xFFFFFFFF stores the written value with the read-only bits kept.
- R10: Writing 0xFFFFFFFF to a BAR makes it read ~(size−1) ORed with its read-only bits. A BAR of size 0 then reads back only its attribute bits.
- R11: Writing 0xFFFFFFFE to the expansion ROM register makes it read 0xFFFFFFFF. Any other 4-byte value is stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W | Byte offset of the access |
| req_size | input | 3 | Access width in bytes (legal: 1, 2, 4) |
| req_wdata | input | 32 | Write data, byte k to offset+k |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Access was illegal |
| rsp_rdata | output | 32 | Read data, zero on writes and errors |

## Verification
The bench aims at the width-dependent permissions. A design that treated offset 0x0C as writable at every width, or that let a word write at 0x04 spill into status, would show a wrong readback or a wrong error flag. BAR probing is run on both I/O and memory BARs, including one of size zero. A design that applied the memory mask to an I/O BAR, or that lost the attribute bits during a probe, would return a wrong sizing mask. The bench also covers illegal size codes, misalignment, offsets past the header, and a long mixed random stream against a behavioural model. A decoder that half-applied a rejected access would leave bytes that differ from the model.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
   localparam int unsigned HDR_BYTES = 64;
   localparam int unsigned NUM_BARS  = 6;
   localparam int unsigned IDX_W     = $clog2(HDR_BYTES);

   // Field offsets; the layout is decoded by software, so positions are fixed
   localparam int unsigned OFS_VENDOR     = 0;
   localparam int unsigned OFS_DEVICE     = 2;
   localparam int unsigned OFS_COMMAND    = 4;
   localparam int unsigned OFS_STATUS     = 6;
   localparam int unsigned OFS_REVISION   = 8;
   localparam int unsigned OFS_CLASS      = 9;
   localparam int unsigned OFS_CACHE_LINE = 12;
   localparam int unsigned OFS_LATENCY    = 13;
   localparam int unsigned OFS_HDR_TYPE   = 14;
   localparam int unsigned OFS_BAR_FIRST  = 16;
   localparam int unsigned OFS_BAR_LAST   = OFS_BAR_FIRST + 4 * (NUM_BARS - 1);
   localparam int unsigned OFS_SUBSYS_VEN = 44;
   localparam int unsigned OFS_SUBSYS_ID  = 46;
   localparam int unsigned OFS_ROM        = 48;
   localparam int unsigned OFS_INT_LINE   = 60;
   localparam int unsigned OFS_INT_PIN    = 61;

   localparam logic [31:0] PROBE_ALL_ONES = 32'hFFFF_FFFF;
   localparam logic [31:0] ROM_PROBE      = 32'hFFFF_FFFE;

   typedef enum logic [1:0] {
      WR_NONE  = 2'd0,
      WR_BYTES = 2'd1,
      WR_BAR   = 2'd2,
      WR_ROM   = 2'd3
   } wr_kind_e;

   function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
      return w[8*lane +: 8];
   endfunction
endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
   import cfg_hdr_pkg::*;
#(
   parameter int unsigned OFS_W = 8
)(
   input  logic [OFS_W-1:0]     req_offset,
   input  logic [2:0]           req_size,
   input  logic                 req_write,
   output logic                 acc_err,
   output wr_kind_e             wr_kind,
   output logic [HDR_BYTES-1:0] byte_we,
   output logic [2:0]           bar_sel
);
   localparam int unsigned BAR_SPAN = 4 * NUM_BARS;

   generate
      if (OFS_W < IDX_W) begin : g_bad_width
         $error("cfg_access_decode: OFS_W must cover the header");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             size_ok, align_ok, range_ok, fmt_ok;

   assign idx = req_offset[IDX_W-1:0];

   generate
      if (OFS_W > IDX_W) begin : g_range_chk
         assign range_ok = (req_offset[OFS_W-1:IDX_W] == '0);
      end else begin : g_range_free
         assign range_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      size_ok  = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
      unique case (req_size)
         3'd2:    align_ok = ~idx[0];
         3'd4:    align_ok = (idx[1:0] == 2'b00);
         default: align_ok = 1'b1;
      endcase
      fmt_ok = size_ok && align_ok && range_ok;
   end

   always_comb begin
      acc_err = 1'b0;
      wr_kind = WR_NONE;
      byte_we = '0;
      bar_sel = '0;
      if (!fmt_ok) begin
         acc_err = 1'b1;
      end else if (req_write) begin
         unique case (req_size)
            3'd1: begin
               if (idx == IDX_W'(OFS_CACHE_LINE) || idx == IDX_W'(OFS_LATENCY) ||
                   idx == IDX_W'(OFS_INT_LINE)) begin
                  wr_kind = WR_BYTES;
                  byte_we = HDR_BYTES'(1) << idx;
               end else begin
                  acc_err = 1'b1;
               end
            end
            3'd2: begin
               if (idx == IDX_W'(OFS_COMMAND) || idx == IDX_W'(OFS_STATUS) ||
                   idx == IDX_W'(OFS_CACHE_LINE)) begin
                  wr_kind = WR_BYTES;
                  byte_we = HDR_BYTES'(3) << idx;
               end else begin
                  acc_err = 1'b1;
               end
            end
            default: begin
               if (idx == IDX_W'(OFS_COMMAND)) begin
                  // word write reaches the command half only
                  wr_kind = WR_BYTES;
                  byte_we = HDR_BYTES'(3) << idx;
               end else if (int'(idx) >= OFS_BAR_FIRST && int'(idx) < OFS_BAR_FIRST + BAR_SPAN) begin
                  wr_kind = WR_BAR;
                  bar_sel = 3'((int'(idx) - OFS_BAR_FIRST) >> 2);
               end else if (idx == IDX_W'(OFS_ROM)) begin
                  wr_kind = WR_ROM;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg
   import cfg_hdr_pkg::*;
#(
   parameter logic [31:0] INIT = 32'h0,
   parameter logic [31:0] SIZE = 32'h0
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] value
);
   localparam bit          IS_IO    = INIT[0];
   localparam int unsigned MIN_SIZE = IS_IO ? 4 : 16;
   localparam logic [31:0] SIZE_MSK = ~(SIZE - 32'd1);

   generate
      if (SIZE != 0 && ((SIZE & (SIZE - 32'd1)) != 0)) begin : g_pow2_err
         $error("cfg_bar_reg: SIZE must be a power of two");
      end
      if (SIZE != 0 && SIZE < MIN_SIZE) begin : g_min_err
         $error("cfg_bar_reg: SIZE below the minimum for this BAR kind");
      end
   endgenerate

   logic [31:0] ro_mask;

   generate
      if (IS_IO) begin : g_io
         assign ro_mask = 32'h0000_0003;
      end else begin : g_mem
         assign ro_mask = 32'h0000_000F;
      end
   endgenerate

   logic [31:0] next_val;

   always_comb begin
      if (wr_data == PROBE_ALL_ONES) begin
         next_val = SIZE_MSK | (value & ro_mask);
      end else begin
         next_val = (wr_data & ~ro_mask) | (value & ro_mask);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= INIT;
      end else if (wr_en) begin
         value <= next_val;
      end
   end
endmodule

// File: rtl/cfg_rom_reg.sv
module cfg_rom_reg
   import cfg_hdr_pkg::*;
#(
   parameter logic [31:0] INIT = 32'h0
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] value
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= INIT;
      end else if (wr_en) begin
         value <= (wr_data == ROM_PROBE) ? PROBE_ALL_ONES : wr_data;
      end
   end
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
   import cfg_hdr_pkg::*;
#(
   parameter int unsigned            OFS_W       = 8,
   parameter logic [15:0]            VENDOR_ID   = 16'h1D0F,
   parameter logic [15:0]            DEVICE_ID   = 16'h0042,
   parameter logic [15:0]            CMD_INIT    = 16'h0000,
   parameter logic [15:0]            STATUS_INIT = 16'h0010,
   parameter logic [7:0]             REVISION    = 8'h03,
   parameter logic [23:0]            CLASS_CODE  = 24'h020000,
   parameter logic [7:0]             HDR_TYPE    = 8'h00,
   parameter logic [15:0]            SUBSYS_VEN  = 16'h1D0F,
   parameter logic [15:0]            SUBSYS_ID   = 16'h1100,
   parameter logic [7:0]             INT_LINE    = 8'hFF,
   parameter logic [7:0]             INT_PIN     = 8'h01,
   parameter logic [31:0]            ROM_INIT    = 32'h0000_0000,
   parameter logic [NUM_BARS*32-1:0] BAR_INIT    = {32'h0, 32'h0, 32'h1, 32'h8, 32'h1, 32'h0},
   parameter logic [NUM_BARS*32-1:0] BAR_SIZE    = {32'h10, 32'h0, 32'h4, 32'h10000, 32'h100, 32'h1000}
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [OFS_W-1:0] req_offset,
   input  logic [2:0]       req_size,
   input  logic [31:0]      req_wdata,
   output logic             rsp_valid,
   output logic             rsp_err,
   output logic [31:0]      rsp_rdata
);
   function automatic logic [7:0] init_byte(input int unsigned i);
      case (i)
         OFS_VENDOR:         return VENDOR_ID[7:0];
         OFS_VENDOR + 1:     return VENDOR_ID[15:8];
         OFS_DEVICE:         return DEVICE_ID[7:0];
         OFS_DEVICE + 1:     return DEVICE_ID[15:8];
         OFS_COMMAND:        return CMD_INIT[7:0];
         OFS_COMMAND + 1:    return CMD_INIT[15:8];
         OFS_STATUS:         return STATUS_INIT[7:0];
         OFS_STATUS + 1:     return STATUS_INIT[15:8];
         OFS_REVISION:       return REVISION;
         OFS_CLASS:          return CLASS_CODE[7:0];
         OFS_CLASS + 1:      return CLASS_CODE[15:8];
         OFS_CLASS + 2:      return CLASS_CODE[23:16];
         OFS_HDR_TYPE:       return HDR_TYPE;
         OFS_SUBSYS_VEN:     return SUBSYS_VEN[7:0];
         OFS_SUBSYS_VEN + 1: return SUBSYS_VEN[15:8];
         OFS_SUBSYS_ID:      return SUBSYS_ID[7:0];
         OFS_SUBSYS_ID + 1:  return SUBSYS_ID[15:8];
         OFS_INT_LINE:       return INT_LINE;
         OFS_INT_PIN:        return INT_PIN;
         default:            return 8'h00;
      endcase
   endfunction

   logic                 acc_err;
   wr_kind_e             wr_kind;
   logic [HDR_BYTES-1:0] byte_we;
   logic [2:0]           bar_sel;
   logic [IDX_W-1:0]     idx;

   assign idx = req_offset[IDX_W-1:0];

   cfg_access_decode #(.OFS_W(OFS_W)) u_decode (
      .req_offset (req_offset),
      .req_size   (req_size),
      .req_write  (req_write),
      .acc_err    (acc_err),
      .wr_kind    (wr_kind),
      .byte_we    (byte_we),
      .bar_sel    (bar_sel)
   );

   // Plain byte fields: one flop per byte, constants fold away
   logic [7:0] hdr_q     [HDR_BYTES];
   logic [7:0] lane_data [HDR_BYTES];

   always_comb begin
      for (int i = 0; i < HDR_BYTES; i++) begin
         lane_data[i] = lane_byte(req_wdata, 2'(i) - idx[1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < HDR_BYTES; i++) hdr_q[i] <= init_byte(i);
      end else if (req_valid && wr_kind == WR_BYTES) begin
         for (int i = 0; i < HDR_BYTES; i++) begin
            if (byte_we[i]) hdr_q[i] <= lane_data[i];
         end
      end
   end

   // Base address registers
   logic [31:0] bar_val [NUM_BARS];

   generate
      for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
         logic bar_we;
         assign bar_we = req_valid && (wr_kind == WR_BAR) && (bar_sel == 3'(b));
         cfg_bar_reg #(
            .INIT (BAR_INIT[32*b +: 32]),
            .SIZE (BAR_SIZE[32*b +: 32])
         ) u_bar (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bar_we),
            .wr_data (req_wdata),
            .value   (bar_val[b])
         );
      end
   endgenerate

   logic [31:0] rom_val;
   logic        rom_we;

   assign rom_we = req_valid && (wr_kind == WR_ROM);

   cfg_rom_reg #(.INIT(ROM_INIT)) u_rom (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rom_we),
      .wr_data (req_wdata),
      .value   (rom_val)
   );

   // Assembled view of the header for reads
   logic [7:0] view [HDR_BYTES];

   always_comb begin
      for (int i = 0; i < HDR_BYTES; i++) view[i] = hdr_q[i];
      for (int b = 0; b < NUM_BARS; b++) begin
         for (int k = 0; k < 4; k++) view[OFS_BAR_FIRST + 4*b + k] = bar_val[b][8*k +: 8];
      end
      for (int k = 0; k < 4; k++) view[OFS_ROM + k] = rom_val[8*k +: 8];
   end

   logic [31:0] rd_word;

   always_comb begin
      rd_word = '0;
      if (!acc_err && !req_write) begin
         for (int k = 0; k < 4; k++) begin
            if (k < int'(req_size)) rd_word[8*k +: 8] = view[IDX_W'(idx + IDX_W'(k))];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && acc_err;
         rsp_rdata <= req_valid ? rd_word : '0;
      end
   end
endmodule

// File: rtl/cfg_header_regs_chk.sv
module cfg_header_regs_chk #(
   parameter int unsigned OFS_W = 8
)(
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic [OFS_W-1:0] req_offset,
   input logic [2:0]       req_size,
   input logic             rsp_valid,
   input logic             rsp_err,
   input logic [31:0]      rsp_rdata
);
   logic size_bad, misplaced;

   assign size_bad  = !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4);
   assign misplaced = (req_size == 3'd2 && req_offset[0]) ||
                      (req_size == 3'd4 && req_offset[1:0] != 2'b00) ||
                      (int'(req_offset) >= 64);

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);                                                  // R1
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);                                                // R1
   AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == 32'h0));                        // R1
   AST_BYTE_READ_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 3'd1) |=> (rsp_rdata[31:8] == 24'h0)); // R3
   AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && size_bad) |=> rsp_err);                                      // R4
   AST_MISPLACED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && misplaced) |=> rsp_err);                                     // R5
   AST_ERR_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));                          // R5
   AST_BYTE_RO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == 3'd1 && req_offset == '0) |=> rsp_err); // R6
   AST_HALF_RO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == 3'd2 && req_offset == '0) |=> rsp_err); // R7
   AST_WORD_RO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == 3'd4 && req_offset == '0) |=> !rsp_err); // R8
endmodule

bind cfg_header_regs cfg_header_regs_chk #(.OFS_W(OFS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_offset (req_offset),
   .req_size   (req_size),
   .rsp_valid  (rsp_valid),
   .rsp_err    (rsp_err),
   .rsp_rdata  (rsp_rdata)
);

// File: tb/cfg_header_regs_tb.sv
`timescale 1ns/1ps
module cfg_header_regs_tb;
   localparam logic [15:0]  T_VENDOR  = 16'hA5C3;
   localparam logic [15:0]  T_DEVICE  = 16'h7E21;
   localparam logic [15:0]  T_CMD     = 16'h0000;
   localparam logic [15:0]  T_STATUS  = 16'h0230;
   localparam logic [7:0]   T_REV     = 8'h11;
   localparam logic [23:0]  T_CLASS   = 24'h0C0330;
   localparam logic [7:0]   T_HTYPE   = 8'h00;
   localparam logic [15:0]  T_SSVEN   = 16'h5A5A;
   localparam logic [15:0]  T_SSID    = 16'hBEEF;
   localparam logic [7:0]   T_ILINE   = 8'h0B;
   localparam logic [7:0]   T_IPIN    = 8'h02;
   localparam logic [31:0]  T_ROM     = 32'h0000_0000;
   localparam logic [191:0] T_BAR_INIT = {32'h4, 32'h0, 32'h1, 32'h8, 32'h1, 32'h0};
   localparam logic [191:0] T_BAR_SIZE = {32'h20, 32'h0, 32'h4, 32'h10000, 32'h100, 32'h1000};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_offset = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cfg_header_regs #(
      .OFS_W(8), .VENDOR_ID(T_VENDOR), .DEVICE_ID(T_DEVICE), .CMD_INIT(T_CMD),
      .STATUS_INIT(T_STATUS), .REVISION(T_REV), .CLASS_CODE(T_CLASS),
      .HDR_TYPE(T_HTYPE), .SUBSYS_VEN(T_SSVEN), .SUBSYS_ID(T_SSID),
      .INT_LINE(T_ILINE), .INT_PIN(T_IPIN), .ROM_INIT(T_ROM),
      .BAR_INIT(T_BAR_INIT), .BAR_SIZE(T_BAR_SIZE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   // Behavioural reference: flat byte image plus BAR sizes
   logic [7:0]  img [64];
   logic [31:0] bsize [6];

   function automatic logic [31:0] get32(input int o);
      return {img[o+3], img[o+2], img[o+1], img[o]};
   endfunction

   function automatic void put32(input int o, input logic [31:0] v);
      for (int k = 0; k < 4; k++) img[o+k] = v[8*k +: 8];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 64; i++) img[i] = 8'h00;
      img[0] = T_VENDOR[7:0];  img[1] = T_VENDOR[15:8];
      img[2] = T_DEVICE[7:0];  img[3] = T_DEVICE[15:8];
      img[4] = T_CMD[7:0];     img[5] = T_CMD[15:8];
      img[6] = T_STATUS[7:0];  img[7] = T_STATUS[15:8];
      img[8] = T_REV;
      img[9] = T_CLASS[7:0];   img[10] = T_CLASS[15:8]; img[11] = T_CLASS[23:16];
      img[14] = T_HTYPE;
      for (int b = 0; b < 6; b++) begin
         put32(16 + 4*b, T_BAR_INIT[32*b +: 32]);
         bsize[b] = T_BAR_SIZE[32*b +: 32];
      end
      img[44] = T_SSVEN[7:0];  img[45] = T_SSVEN[15:8];
      img[46] = T_SSID[7:0];   img[47] = T_SSID[15:8];
      put32(48, T_ROM);
      img[60] = T_ILINE;
      img[61] = T_IPIN;
   endtask

   task automatic model_access(input bit w, input int off, input int sz, input logic [31:0] d,
                               output logic e, output logic [31:0] rd);
      logic [31:0] keep, cur;
      e  = 0;
      rd = 0;
      if (!(sz == 1 || sz == 2 || sz == 4) || (off % sz) != 0 || off >= 64) begin
         e = 1;
         return;
      end
      if (!w) begin
         for (int k = 0; k < sz; k++) rd[8*k +: 8] = img[off+k];
         return;
      end
      if (sz == 1) begin
         if (off == 12 || off == 13 || off == 60) img[off] = d[7:0];
         else e = 1;
      end else if (sz == 2) begin
         if (off == 4 || off == 6 || off == 12) begin
            img[off] = d[7:0];
            img[off+1] = d[15:8];
         end else e = 1;
      end else begin
         if (off == 4) begin
            img[4] = d[7:0];
            img[5] = d[15:8];
         end else if (off >= 16 && off <= 36) begin
            cur  = get32(off);
            keep = cur[0] ? 32'h3 : 32'hF;
            if (d == 32'hFFFF_FFFF) put32(off, ~(bsize[(off-16)/4] - 1) | (cur & keep));
            else                    put32(off, (d & ~keep) | (cur & keep));
         end else if (off == 48) begin
            put32(48, (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d);
         end
      end
   endtask

   // Called at a falling edge; returns at the next falling edge after checking
   task automatic access(input bit w, input int off, input int sz, input logic [31:0] d,
                         input string rq);
      logic        ee;
      logic [31:0] er;
      model_access(w, off, sz, d, ee, er);
      req_valid  = 1;
      req_write  = w;
      req_offset = off[7:0];
      req_size   = sz[2:0];
      req_wdata  = d;
      @(negedge clk);
      req_valid = 0;
      checks++;
      if (rsp_valid !== 1'b1 || rsp_err !== ee || rsp_rdata !== er) begin
         errors++;
         $display("FAIL %s: %s off=0x%0h size=%0d actual valid=%b err=%b data=0x%08h expected valid=1 err=%b data=0x%08h",
                  rq, w ? "wr" : "rd", off, sz, rsp_valid, rsp_err, rsp_rdata, ee, er);
      end
   endtask

   task automatic idle(input string rq);
      req_valid = 0;
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL %s: idle actual valid=%b expected valid=0", rq, rsp_valid);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_rdata !== 32'h0) begin
         errors++;
         $display("FAIL R1 reset: actual valid=%b err=%b data=0x%08h expected 0/0/0",
                  rsp_valid, rsp_err, rsp_rdata);
      end
      rst_n = 1;
      @(negedge clk);
      idle("R1");

      // R2: full reset image, word by word
      for (int o = 0; o < 64; o += 4) access(0, o, 4, 32'h0, "R2");
      // R3: narrow reads, little-endian, zero-extended
      access(0, 0, 2, 32'h0, "R3");
      access(0, 2, 2, 32'h0, "R3");
      access(0, 11, 1, 32'h0, "R3");
      access(0, 61, 1, 32'h0, "R3");
      access(0, 45, 1, 32'h0, "R3");

      // R4: illegal size codes
      access(0, 0, 3, 32'h0, "R4");
      access(1, 12, 3, 32'h1234_5678, "R4");
      access(1, 60, 0, 32'h77, "R4");
      access(0, 8, 7, 32'h0, "R4");
      access(0, 12, 4, 32'h0, "R4");

      // R5: misaligned and out of range
      access(0, 1, 2, 32'h0, "R5");
      access(1, 5, 2, 32'hFFFF, "R5");
      access(0, 2, 4, 32'h0, "R5");
      access(1, 18, 4, 32'hFFFF_FFFF, "R5");
      access(0, 64, 1, 32'h0, "R5");
      access(1, 200, 4, 32'h0, "R5");
      access(0, 16, 4, 32'h0, "R5");

      // R6: byte writes
      access(1, 12, 1, 32'hAAAA_AA40, "R6");
      access(1, 13, 1, 32'h0000_0020, "R6");
      access(1, 60, 1, 32'h0000_0009, "R6");
      access(1, 0, 1, 32'h0000_00EE, "R6");
      access(1, 61, 1, 32'h0000_00EE, "R6");
      access(1, 4, 1, 32'h0000_00EE, "R6");
      access(0, 12, 4, 32'h0, "R6");
      access(0, 60, 4, 32'h0, "R6");
      access(0, 4, 4, 32'h0, "R6");

      // R7: half-word writes
      access(1, 4, 2, 32'hDEAD_0107, "R7");
      access(1, 6, 2, 32'h0000_F800, "R7");
      access(1, 12, 2, 32'h0000_3310, "R7");
      access(1, 0, 2, 32'h0000_1111, "R7");
      access(1, 60, 2, 32'h0000_2222, "R7");
      access(1, 8, 2, 32'h0000_3333, "R7");
      access(0, 0, 4, 32'h0, "R7");
      access(0, 4, 4, 32'h0, "R7");
      access(0, 12, 4, 32'h0, "R7");

      // R8: word writes
      access(1, 4, 4, 32'hCAFE_0006, "R8");
      access(0, 4, 4, 32'h0, "R8");
      access(1, 0, 4, 32'h1234_5678, "R8");
      access(1, 8, 4, 32'h9999_9999, "R8");
      access(1, 12, 4, 32'h5555_5555, "R8");
      access(1, 44, 4, 32'h0BAD_F00D, "R8");
      access(1, 60, 4, 32'hFFFF_FFFF, "R8");
      access(0, 0, 4, 32'h0, "R8");
      access(0, 8, 4, 32'h0, "R8");
      access(0, 12, 4, 32'h0, "R8");
      access(0, 44, 4, 32'h0, "R8");
      access(0, 60, 4, 32'h0, "R8");

      // R10: sizing probe on every BAR, I/O and memory
      for (int b = 0; b < 6; b++) begin
         access(1, 16 + 4*b, 4, 32'hFFFF_FFFF, "R10");
         access(0, 16 + 4*b, 4, 32'h0, "R10");
      end

      // R9: base writes with junk in the attribute bits
      for (int b = 0; b < 6; b++) begin
         access(1, 16 + 4*b, 4, 32'hF123_456E ^ (b << 12), "R9");
         access(0, 16 + 4*b, 4, 32'h0, "R9");
      end
      access(1, 20, 4, 32'h0000_0000, "R9");
      access(0, 20, 4, 32'h0, "R9");
      access(0, 20, 1, 32'h0, "R9");

      // R11: expansion ROM
      access(1, 48, 4, 32'hFFFF_FFFE, "R11");
      access(0, 48, 4, 32'h0, "R11");
      access(1, 48, 4, 32'hFFFF_FFFF, "R11");
      access(0, 48, 4, 32'h0, "R11");
      access(1, 48, 4, 32'hFEED_0001, "R11");
      access(0, 48, 4, 32'h0, "R11");
      access(0, 50, 2, 32'h0, "R11");

      // R1: back-to-back write then read, then idle
      access(1, 6, 2, 32'h0000_0A0A, "R1");
      access(0, 6, 2, 32'h0, "R1");
      idle("R1");

      // Mixed stream against the model, with idles between
      for (int n = 0; n < 1500; n++) begin
         int sel, sz, off;
         logic [31:0] d;
         sel = int'($urandom_range(0, 9));
         sz  = (sel < 3) ? 1 : (sel < 6) ? 2 : (sel < 9) ? 4 : int'($urandom_range(0, 7));
         off = int'($urandom_range(0, 71));
         if ($urandom_range(0, 4) != 0 && sz != 0) off = off - (off % sz);
         d = $urandom();
         if ($urandom_range(0, 7) == 0) d = 32'hFFFF_FFFF;
         if ($urandom_range(0, 15) == 0) d = 32'hFFFF_FFFE;
         access(bit'($urandom_range(0, 1)), off, sz, d, "R1 R3 R6 R7 R8 R9 R10 R11 mix");
         if ($urandom_range(0, 5) == 0) idle("R1");
      end
      for (int o = 0; o < 64; o += 4) access(0, o, 4, 32'h0, "R2 final image");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule